// File: doc/BRIEF.md
# Vector condition-code test unit

This unit keeps a four-lane condition-code register for a vector shader datapath and decides, lane by lane, whether an instruction's result may be written back. Each lane of the register holds a 2-bit code that records whether the last value written to that lane was negative, zero or positive. An instruction can ask to refresh these codes from its own result vector. Only the lanes enabled by its destination write mask are refreshed, and the new codes take effect at the next clock edge.

An instruction can also ask for a conditional test. The stored codes pass through a swizzle first, so any stored lane can drive the test of any output lane. Each swizzled code is then compared against a 3-bit condition selector. The outcome gates the write mask into a commit mask. The swizzled x lane alone also gives a branch-taken flag. A loop is built as a counter kept in a temporary register followed by a conditional branch on this flag. Both outputs are registered: they describe the instruction presented one cycle earlier.

Top module: `vcc_test_unit`

## Requirements
- R1: While `rst` is high at a clock edge, every stored lane code becomes the zero code, and `commit_mask` and `branch_taken` become 0.
- R2: When `cc_test_en` is 0, `commit_mask` one cycle later equals `wr_mask` and `branch_taken` is 1.
- R3: The condition selector `cc_cond` is read as three flags. Bit 0 passes a negative code, bit 1 passes a zero code and bit 2 passes a positive code. This gives 0 never, 1 less, 2 equal, 3 less-or-equal, 4 greater, 5 not-equal, 6 greater-or-equal and 7 always.
- R4: `cc_swz` holds one 2-bit selector per output lane. Bits 7:6 serve lane x, bits 5:4 lane y, bits 3:2 lane z and bits 1:0 lane w. A selector value of 0, 1, 2 or 3 picks stored lane x, y, z or w.
- R5: When `cc_test_en` is 1, bit i of `commit_mask` one cycle later is `wr_mask[i]` AND the condition test of swizzled lane i.
- R6: When `cc_test_en` is 1, `branch_taken` one cycle later is the condition test of swizzled lane x, whatever `wr_mask` holds.
- R7: When `cc_update_en` is 1, each lane i with `wr_mask[i]` set stores a new code from result lane i, which is a signed 16-bit value at `res_vec[16*i +: 16]`. A value below zero gives the negative code, a value equal to zero gives the zero code, and a value above zero gives the positive code. Lanes with the mask bit clear keep their codes, and nothing is stored when `cc_update_en` is 0.
- R8: An instruction that both tests and updates is tested against the codes held before its own update. The new codes are seen from the next instruction on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cc_update_en | input | 1 | Store result status into the condition register |
| cc_test_en | input | 1 | Gate the commit by the condition test |
| cc_cond | input | 3 | Condition selector (flags for less, equal, greater) |
| cc_swz | input | 8 | Per-lane selectors that pick which stored code each lane tests |
| res_vec | input | 64 | Result vector, four signed 16-bit lanes, lane x lowest |
| wr_mask | input | 4 | Destination write mask, bit 0 = lane x |
| commit_mask | output | 4 | Registered per-lane commit permission |
| branch_taken | output | 1 | Registered branch decision from swizzled lane x |

## Verification
The bench runs every condition value against stored codes that mix negative, zero and positive lanes. A design that decoded the selector flags in the wrong order would swap less and greater. A broadcast swizzle and a swizzle that feeds lane z into x are also tested; a design that read the selector fields in reverse order, or tested the unswizzled register, would give the wrong commit mask and the wrong branch. Partial-mask updates with `cc_update_en` both high and low are checked afterwards through tests, which exposes a design that writes masked-off lanes. A combined test-and-update instruction exposes a design that forwards the new codes into the same cycle's decision.

// File: rtl/vcc_pkg.sv
package vcc_pkg;
  localparam logic [1:0] CC_POS  = 2'b00;
  localparam logic [1:0] CC_ZERO = 2'b01;
  localparam logic [1:0] CC_NEG  = 2'b10;

  // cond bit0 = accept negative, bit1 = accept zero, bit2 = accept positive
  function automatic logic cond_pass(input logic [1:0] code, input logic [2:0] cond);
    return ((code == CC_NEG)  && cond[0]) ||
           ((code == CC_ZERO) && cond[1]) ||
           ((code == CC_POS)  && cond[2]);
  endfunction
endpackage

// File: rtl/vcc_classify.sv
module vcc_classify #(
  parameter int LANES  = 4,
  parameter int DATA_W = 16
) (
  input  logic [LANES*DATA_W-1:0] res_vec,
  output logic [LANES-1:0][1:0]   codes
);
  import vcc_pkg::*;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [DATA_W-1:0] v;
    assign v = res_vec[i*DATA_W +: DATA_W];
    always_comb begin
      if (v[DATA_W-1])    codes[i] = CC_NEG;
      else if (v == '0)   codes[i] = CC_ZERO;
      else                codes[i] = CC_POS;
    end
  end
endmodule

// File: rtl/vcc_ccreg.sv
module vcc_ccreg #(
  parameter int LANES = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  upd_en,
  input  logic [LANES-1:0]      lane_we,
  input  logic [LANES-1:0][1:0] new_codes,
  output logic [LANES-1:0][1:0] cur_codes
);
  import vcc_pkg::*;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)                          cur_codes[i] <= CC_ZERO;
      else if (upd_en && lane_we[i])    cur_codes[i] <= new_codes[i];
    end
  end
endmodule

// File: rtl/vcc_lane_test.sv
module vcc_lane_test #(
  parameter int LANES = 4,
  localparam int SEL_W = $clog2(LANES)
) (
  input  logic [LANES-1:0][1:0]   cur_codes,
  input  logic [LANES*SEL_W-1:0]  swz,
  input  logic [2:0]              cond,
  output logic [LANES-1:0]        pass
);
  import vcc_pkg::*;

  // lane x takes the most significant selector field
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [SEL_W-1:0] sel;
    logic [1:0]       picked;
    assign sel    = swz[(LANES-1-i)*SEL_W +: SEL_W];
    assign picked = cur_codes[sel];
    assign pass[i] = cond_pass(picked, cond);
  end
endmodule

// File: rtl/vcc_test_unit.sv
module vcc_test_unit #(
  parameter int LANES  = 4,
  parameter int DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cc_update_en,
  input  logic                          cc_test_en,
  input  logic [2:0]                    cc_cond,
  input  logic [LANES*$clog2(LANES)-1:0] cc_swz,
  input  logic [LANES*DATA_W-1:0]       res_vec,
  input  logic [LANES-1:0]              wr_mask,
  output logic [LANES-1:0]              commit_mask,
  output logic                          branch_taken
);
  logic [LANES-1:0][1:0] new_codes;
  logic [LANES-1:0][1:0] cur_codes;
  logic [LANES-1:0]      pass;

  vcc_classify #(.LANES(LANES), .DATA_W(DATA_W)) u_classify (
    .res_vec (res_vec),
    .codes   (new_codes)
  );

  vcc_ccreg #(.LANES(LANES)) u_ccreg (
    .clk       (clk),
    .rst       (rst),
    .upd_en    (cc_update_en),
    .lane_we   (wr_mask),
    .new_codes (new_codes),
    .cur_codes (cur_codes)
  );

  vcc_lane_test #(.LANES(LANES)) u_test (
    .cur_codes (cur_codes),
    .swz       (cc_swz),
    .cond      (cc_cond),
    .pass      (pass)
  );

  // decision uses the codes held before this instruction's own update
  always_ff @(posedge clk) begin
    if (rst) begin
      commit_mask  <= '0;
      branch_taken <= 1'b0;
    end else if (cc_test_en) begin
      commit_mask  <= wr_mask & pass;
      branch_taken <= pass[0];
    end else begin
      commit_mask  <= wr_mask;
      branch_taken <= 1'b1;
    end
  end
endmodule

// File: rtl/vcc_test_unit_chk.sv
module vcc_test_unit_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cc_test_en,
  input logic [2:0]       cc_cond,
  input logic [LANES-1:0] wr_mask,
  input logic [LANES-1:0] commit_mask,
  input logic             branch_taken
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (commit_mask == '0) && !branch_taken);

  // R2
  test_off_pass_chk: assert property (@(posedge clk) disable iff (rst)
    !cc_test_en |=> (commit_mask == $past(wr_mask)) && branch_taken);

  // R3
  never_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (cc_test_en && cc_cond == 3'd0) |=> (commit_mask == '0) && !branch_taken);

  // R3
  always_passes_chk: assert property (@(posedge clk) disable iff (rst)
    (cc_test_en && cc_cond == 3'd7) |=> (commit_mask == $past(wr_mask)) && branch_taken);

  // R5
  commit_in_mask_chk: assert property (@(posedge clk) disable iff (rst)
    cc_test_en |=> (commit_mask & ~$past(wr_mask)) == '0);
endmodule

bind vcc_test_unit vcc_test_unit_chk #(.LANES(LANES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cc_test_en   (cc_test_en),
  .cc_cond      (cc_cond),
  .wr_mask      (wr_mask),
  .commit_mask  (commit_mask),
  .branch_taken (branch_taken)
);

// File: tb/vcc_test_unit_tb_top.sv
module vcc_test_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cc_update_en = 1'b0;
  logic        cc_test_en = 1'b0;
  logic [2:0]  cc_cond = '0;
  logic [7:0]  cc_swz = 8'b00_01_10_11;
  logic [63:0] res_vec = '0;
  logic [3:0]  wr_mask = '0;
  logic [3:0]  commit_mask;
  logic        branch_taken;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [1:0] cc_m [4];

  localparam logic [7:0] SWZ_ID = 8'b00_01_10_11;

  always #2 clk = ~clk;

  vcc_test_unit dut_i (
    .clk(clk), .rst(rst), .cc_update_en(cc_update_en), .cc_test_en(cc_test_en),
    .cc_cond(cc_cond), .cc_swz(cc_swz), .res_vec(res_vec), .wr_mask(wr_mask),
    .commit_mask(commit_mask), .branch_taken(branch_taken)
  );

  function automatic logic [1:0] code_of(input logic [15:0] v);
    if (v[15])       return 2'b10;
    else if (v == 0) return 2'b01;
    else             return 2'b00;
  endfunction

  function automatic logic passes(input logic [1:0] c, input logic [2:0] cond);
    return (c == 2'b10 && cond[0]) || (c == 2'b01 && cond[1]) || (c == 2'b00 && cond[2]);
  endfunction

  function automatic logic [63:0] pack(input int x, input int y, input int z, input int w);
    return {w[15:0], z[15:0], y[15:0], x[15:0]};
  endfunction

  task automatic check(input string tag, input logic [3:0] am, input logic [3:0] em,
                       input logic ab, input logic eb);
    checks++;
    if (am !== em || ab !== eb) begin
      failures++;
      $display("FAIL %s: commit=%b branch=%b expected commit=%b branch=%b", tag, am, ab, em, eb);
    end
  endtask

  task automatic do_op(input string tag, input logic upd, input logic tst, input logic [2:0] cond,
                       input logic [7:0] swz, input logic [63:0] res, input logic [3:0] mask);
    logic [3:0] em;
    logic eb;
    logic [3:0] p;
    for (int i = 0; i < 4; i++) p[i] = passes(cc_m[swz[(3-i)*2 +: 2]], cond);
    em = tst ? (mask & p) : mask;
    eb = tst ? p[0] : 1'b1;
    @(negedge clk);
    cc_update_en = upd; cc_test_en = tst; cc_cond = cond; cc_swz = swz;
    res_vec = res; wr_mask = mask;
    @(posedge clk);
    if (upd) for (int i = 0; i < 4; i++) if (mask[i]) cc_m[i] = code_of(res[16*i +: 16]);
    @(negedge clk);
    check(tag, commit_mask, em, branch_taken, eb);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 reset outputs", commit_mask, 4'b0000, branch_taken, 1'b0);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) cc_m[i] = 2'b01;
    do_op("R1 zero code after reset", 0, 1, 3'd2, SWZ_ID, '0, 4'hF);
    do_op("R3 greater fails on zero", 0, 1, 3'd4, SWZ_ID, '0, 4'hF);
  endtask

  task automatic t_test_off;
    do_op("R2 test off mask 5", 0, 0, 3'd0, SWZ_ID, '0, 4'h5);
    do_op("R2 test off mask A", 0, 0, 3'd0, SWZ_ID, '0, 4'hA);
  endtask

  task automatic t_update_conds;
    do_op("R7 load -3,0,7,0", 1, 0, 3'd0, SWZ_ID, pack(-3, 0, 7, 0), 4'hF);
    for (int c = 0; c < 8; c++) do_op("R3 condition sweep", 0, 1, c[2:0], SWZ_ID, '0, 4'hF);
    do_op("R5 mask and pass", 0, 1, 3'd6, SWZ_ID, '0, 4'h9);
  endtask

  task automatic t_mask_gating;
    do_op("R7 partial update", 1, 0, 3'd0, SWZ_ID, pack(-1, -1, -1, -1), 4'b0010);
    do_op("R7 only y negative", 0, 1, 3'd1, SWZ_ID, '0, 4'hF);
    do_op("R7 update_en low ignored", 0, 0, 3'd0, SWZ_ID, pack(5, 5, 5, 5), 4'hF);
    do_op("R7 codes unchanged", 0, 1, 3'd1, SWZ_ID, '0, 4'hF);
  endtask

  task automatic t_swizzle;
    do_op("R4 broadcast y", 0, 1, 3'd1, 8'b01_01_01_01, '0, 4'hF);
    do_op("R4 reversed", 0, 1, 3'd4, 8'b11_10_01_00, '0, 4'hF);
    do_op("R6 branch from z", 0, 1, 3'd4, 8'b10_00_00_00, '0, 4'h0);
    do_op("R6 branch from w", 0, 1, 3'd4, 8'b11_00_00_00, '0, 4'h0);
  endtask

  task automatic t_read_old;
    do_op("R8 load positives", 1, 0, 3'd0, SWZ_ID, pack(4, 4, 4, 4), 4'hF);
    do_op("R8 test sees old", 1, 1, 3'd4, SWZ_ID, pack(-2, -2, -2, -2), 4'hF);
    do_op("R8 next sees new", 0, 1, 3'd1, SWZ_ID, '0, 4'hF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_test_off();
    t_update_conds();
    t_mask_gating();
    t_swizzle();
    t_read_old();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule